// File: doc/BRIEF.md
# Reversible Gate Evaluator

This block evaluates one of four classic reversible logic gates on a four-lane bit vector. Each request carries a gate code, a direction flag and the vector. In the forward direction the block returns the gate's output vector. In the backward direction it treats the vector as a gate output and returns the input that produced it. Every supported gate is a bijection on its lanes, so a forward pass followed by a backward pass always gives back the original operand.

Requests enter through a valid/ready handshake and results leave through one. A transfer happens on a rising clock edge where valid and ready are both high. The upstream side must hold `in_sel`, `in_dir` and `in_vec` steady while `in_valid` is high and `in_ready` is low. The block raises `in_ready` whenever its result slot is empty or the consumer is taking the current result. While `out_valid` is high and `out_ready` is low, `out_vec` does not change. The parameter `OUT_REG` selects the output path. With 1, a single register stage sits between the gate logic and the output. With 0, the result path is purely combinational and the handshake passes straight through.

Lane i of a vector is bit i. Inputs A, B, C and D sit on lanes 0 to 3. Outputs P, Q, R and S sit on lanes 0 to 3.

Top module: `rev_gate_eval`

## Requirements
- R1: Lane 0 of every result equals lane 0 of the operand for every gate and direction. Code 2'b00 is the controlled-NOT gate. Going forward it gives lane1 = A xor B. Going backward it gives lane1 = P xor Q.
- R2: The controlled-NOT inverse recovers B as Q when P is 0, and as not Q when P is 1.
- R3: Code 2'b01 is the controlled swap. Going forward it gives Q=B and R=C when A=0, and Q=C and R=B when A=1.
- R4: The controlled-swap inverse gives B=Q and C=R when P=0, and C=Q and B=R when P=1.
- R5: Code 2'b10 is the doubly controlled NOT. Going forward it gives lane1=B and lane2=(A and B) xor C. Going backward it gives C=R when P and Q are not both 1, and C=not R when they are.
- R6: Code 2'b11 is the four-lane adder gate. Going forward it gives P=A, Q=B, R=A^B^C and S=((A^B)&C)^(A&B)^D.
- R7: The adder-gate inverse gives C=R^P^Q and then D=S^((P^Q)&C)^(P&Q), using the recovered C.
- R8: For every gate and every operand, the backward result of the forward result equals the operand with the gate's unused lanes cleared.
- R9: Result lanes above the selected gate's width are zero: lanes 3:2 for code 00, and lane 3 for codes 01 and 10. Operand lanes above that width have no effect on the result.
- R10: While `out_valid` is high and `out_ready` is low, `out_vec` holds, `out_valid` stays high and (with `OUT_REG`=1) `in_ready` is low. A request offered during the stall is taken only once the stall ends.
- R11: With `OUT_REG`=1, `out_valid` is low after reset and `in_ready` is high.
- R12: With `OUT_REG`=1, an accepted request shows its result with `out_valid` high from the next clock edge. With `OUT_REG`=0, the result appears in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_sel | input | 2 | Gate code |
| in_dir | input | 1 | 0 forward, 1 backward |
| in_vec | input | 4 | Operand lanes |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | 4 | Result lanes |

## Verification
The bench builds two copies side by side with the same stimulus: one with `OUT_REG`=1 and one with `OUT_REG`=0. The registered copy exposes the one-cycle latency, stalls under back-pressure and the reset state. The combinational copy confirms that the gate logic alone gives the same values within the request cycle. Since only 128 combinations of code, direction and operand exist, all of them are covered, along with the full forward-then-backward round trip for every gate and random traffic.

// File: rtl/rev_gate_pkg.sv
package rev_gate_pkg;

  localparam int LANES     = 4;
  localparam int NUM_GATES = 4;
  localparam int SEL_W     = $clog2(NUM_GATES);

  typedef logic [LANES-1:0] lane_t;

  typedef enum logic [SEL_W-1:0] {
    GATE_CNOT  = 2'b00,
    GATE_CSWAP = 2'b01,
    GATE_CCNOT = 2'b10,
    GATE_ADD4  = 2'b11
  } gate_e;

  // Lanes a gate actually uses
  function automatic lane_t lane_mask(gate_e g);
    case (g)
      GATE_CNOT:  return 4'b0011;
      GATE_CSWAP: return 4'b0111;
      GATE_CCNOT: return 4'b0111;
      default:    return 4'b1111;
    endcase
  endfunction

  function automatic lane_t gate_forward(gate_e g, lane_t v);
    lane_t o;
    o = '0;
    case (g)
      GATE_CNOT: begin
        o[0] = v[0];
        o[1] = v[0] ^ v[1];
      end
      GATE_CSWAP: begin
        o[0] = v[0];
        o[1] = v[0] ? v[2] : v[1];
        o[2] = v[0] ? v[1] : v[2];
      end
      GATE_CCNOT: begin
        o[0] = v[0];
        o[1] = v[1];
        o[2] = (v[0] & v[1]) ^ v[2];
      end
      default: begin
        o[0] = v[0];
        o[1] = v[1];
        o[2] = v[0] ^ v[1] ^ v[2];
        o[3] = ((v[0] ^ v[1]) & v[2]) ^ (v[0] & v[1]) ^ v[3];
      end
    endcase
    return o;
  endfunction

  function automatic lane_t gate_backward(gate_e g, lane_t v);
    lane_t o;
    logic  c_rec;
    o     = '0;
    c_rec = 1'b0;
    case (g)
      GATE_CNOT: begin
        o[0] = v[0];
        o[1] = v[0] ? ~v[1] : v[1];
      end
      GATE_CSWAP: begin
        o[0] = v[0];
        o[1] = v[0] ? v[2] : v[1];
        o[2] = v[0] ? v[1] : v[2];
      end
      GATE_CCNOT: begin
        o[0] = v[0];
        o[1] = v[1];
        o[2] = (v[0] & v[1]) ? ~v[2] : v[2];
      end
      default: begin
        c_rec = v[2] ^ v[0] ^ v[1];
        o[0]  = v[0];
        o[1]  = v[1];
        o[2]  = c_rec;
        o[3]  = v[3] ^ ((v[0] ^ v[1]) & c_rec) ^ (v[0] & v[1]);
      end
    endcase
    return o;
  endfunction

endpackage

// File: rtl/rev_gate_fwd.sv
module rev_gate_fwd
  import rev_gate_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  lane_t            vec,
  output lane_t            res
);

  lane_t cand [NUM_GATES];

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    assign cand[g] = gate_forward(gate_e'(g), vec & lane_mask(gate_e'(g)));
  end

  assign res = cand[sel];

endmodule

// File: rtl/rev_gate_inv.sv
module rev_gate_inv
  import rev_gate_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  lane_t            vec,
  output lane_t            res
);

  lane_t cand [NUM_GATES];

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    assign cand[g] = gate_backward(gate_e'(g), vec & lane_mask(gate_e'(g)));
  end

  assign res = cand[sel];

endmodule

// File: rtl/rev_gate_stage.sv
module rev_gate_stage #(
  parameter int  W       = 4,
  parameter bit  OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  if (OUT_REG) begin : g_reg
    logic         full_q;
    logic [W-1:0] data_q;

    assign in_ready = !full_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        data_q <= '0;
      end else if (in_ready) begin
        full_q <= in_valid;
        if (in_valid) data_q <= in_data;
      end
    end

    assign out_valid = full_q;
    assign out_data  = data_q;
  end else begin : g_pass
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end

endmodule

// File: rtl/rev_gate_eval.sv
module rev_gate_eval
  import rev_gate_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_sel,
  input  logic       in_dir,
  input  logic [3:0] in_vec,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [3:0] out_vec
);

  lane_t fwd_res;
  lane_t inv_res;
  lane_t res;

  rev_gate_fwd u_fwd (
    .sel (in_sel),
    .vec (in_vec),
    .res (fwd_res)
  );

  rev_gate_inv u_inv (
    .sel (in_sel),
    .vec (in_vec),
    .res (inv_res)
  );

  assign res = in_dir ? inv_res : fwd_res;

  rev_gate_stage #(
    .W       (LANES),
    .OUT_REG (OUT_REG)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_vec)
  );

endmodule

// File: rtl/rev_gate_eval_chk.sv
module rev_gate_eval_chk
  import rev_gate_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_sel,
  input logic [3:0] in_vec,
  input logic [3:0] fwd_res,
  input logic [3:0] res,
  input logic       out_valid,
  input logic       out_ready,
  input logic [3:0] out_vec
);

  lane_t round_trip;

  rev_gate_inv u_rt (
    .sel (in_sel),
    .vec (fwd_res),
    .res (round_trip)
  );

  AST_LANE0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    res[0] == in_vec[0]); // R1

  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    round_trip == (in_vec & lane_mask(gate_e'(in_sel)))); // R8

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res & ~lane_mask(gate_e'(in_sel))) == 4'b0000); // R9

  if (OUT_REG) begin : g_reg_chk
    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_vec)); // R10

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready); // R10

    AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid); // R12

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid); // R11
  end

endmodule

bind rev_gate_eval rev_gate_eval_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sel    (in_sel),
  .in_vec    (in_vec),
  .fwd_res   (fwd_res),
  .res       (res),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_vec   (out_vec)
);

// File: tb/rev_gate_eval_tb_top.sv
module rev_gate_eval_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [1:0] in_sel;
  logic       in_dir;
  logic [3:0] in_vec;
  logic       out_ready;
  logic       r_in_ready, r_out_valid;
  logic [3:0] r_out_vec;
  logic       c_in_ready, c_out_valid;
  logic [3:0] c_out_vec;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rev_gate_eval #(.OUT_REG(1'b1)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (r_in_ready),
    .in_sel (in_sel), .in_dir (in_dir), .in_vec (in_vec),
    .out_valid (r_out_valid), .out_ready (out_ready), .out_vec (r_out_vec)
  );

  rev_gate_eval #(.OUT_REG(1'b0)) dut_c (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (c_in_ready),
    .in_sel (in_sel), .in_dir (in_dir), .in_vec (in_vec),
    .out_valid (c_out_valid), .out_ready (1'b1), .out_vec (c_out_vec)
  );

  // Expected result from the requirements (lanes: A/P=0 .. D/S=3)
  function automatic logic [3:0] model(logic [1:0] s, logic d, logic [3:0] v);
    logic a, b, c, e, x;
    logic [3:0] o;
    a = v[0]; b = v[1]; c = v[2]; e = v[3];
    o = 4'b0000;
    case (s)
      2'b00: o = {2'b00, a ^ b, a};
      2'b01: o = {1'b0, a ? b : c, a ? c : b, a};
      2'b10: o = {1'b0, (a & b) ^ c, b, a};
      default:
        if (!d) o = {((a ^ b) & c) ^ (a & b) ^ e, a ^ b ^ c, b, a};
        else begin
          x = c ^ a ^ b;
          o = {e ^ ((a ^ b) & x) ^ (a & b), x, b, a};
        end
    endcase
    return o;
  endfunction

  function automatic string req_of(logic [1:0] s, logic d);
    case ({s, d})
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b011:  return "R4";
      3'b100:  return "R5";
      3'b101:  return "R5";
      3'b110:  return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] s, input logic d, input logic [3:0] v,
                        input string req, output logic [3:0] got);
    logic [3:0] exp;
    exp = model(s, d, v);
    @(negedge clk);
    in_sel = s; in_dir = d; in_vec = v; in_valid = 1'b1; out_ready = 1'b1;
    #2;
    chk(c_out_vec === exp, req, c_out_vec, exp);
    @(posedge clk);
    @(negedge clk);
    chk(r_out_valid === 1'b1, "R12", {3'b0, r_out_valid}, 4'b0001);
    chk(r_out_vec === exp, req, r_out_vec, exp);
    got = r_out_vec;
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] got, back, exp1, exp2;
    void'($urandom(32'd20240517));
    rst_n = 1'b0; in_valid = 1'b0; in_sel = 2'b00; in_dir = 1'b0;
    in_vec = 4'b0000; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R11 reset state
    chk(r_out_valid === 1'b0, "R11", {3'b0, r_out_valid}, 4'b0000);
    chk(r_in_ready === 1'b1, "R11", {3'b0, r_in_ready}, 4'b0001);

    // Exhaustive: every code, direction and operand
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 2; d++)
        for (int v = 0; v < 16; v++)
          run_op(2'(s), 1'(d), 4'(v), req_of(2'(s), 1'(d)), got);

    // R8 round trip through the port
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 16; v++) begin
        run_op(2'(s), 1'b0, 4'(v), req_of(2'(s), 1'b0), got);
        run_op(2'(s), 1'b1, got, req_of(2'(s), 1'b1), back);
        exp1 = (s == 0) ? (4'(v) & 4'b0011) : (s == 3) ? 4'(v) : (4'(v) & 4'b0111);
        chk(back === exp1, "R8", back, exp1);
      end

    // R9 directed: upper operand lanes ignored, upper result lanes zero
    run_op(2'b00, 1'b0, 4'b1101, "R9", got);
    chk(got === 4'b0011, "R9", got, 4'b0011);
    run_op(2'b01, 1'b0, 4'b1110, "R9", got);
    chk(got === 4'b0110, "R9", got, 4'b0110);
    run_op(2'b10, 1'b1, 4'b1111, "R9", got);
    chk(got === 4'b0011, "R9", got, 4'b0011);

    // R12 latency: registered copy not valid before the edge
    @(negedge clk);
    in_sel = 2'b11; in_dir = 1'b0; in_vec = 4'b0111; in_valid = 1'b1; out_ready = 1'b0;
    exp1 = model(2'b11, 1'b0, 4'b0111);
    #2;
    chk(r_out_valid === 1'b0, "R12", {3'b0, r_out_valid}, 4'b0000);
    chk(c_out_valid === 1'b1, "R12", {3'b0, c_out_valid}, 4'b0001);
    @(posedge clk);
    @(negedge clk);
    chk(r_out_vec === exp1, "R12", r_out_vec, exp1);
    // R10 stall: new request offered, must wait
    in_vec = 4'b1000;
    exp2 = model(2'b11, 1'b0, 4'b1000);
    #2;
    chk(r_in_ready === 1'b0, "R10", {3'b0, r_in_ready}, 4'b0000);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(r_out_valid === 1'b1, "R10", {3'b0, r_out_valid}, 4'b0001);
      chk(r_out_vec === exp1, "R10", r_out_vec, exp1);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(r_out_vec === exp2, "R10", r_out_vec, exp2);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(r_out_valid === 1'b0, "R10", {3'b0, r_out_valid}, 4'b0000);

    // Random traffic
    for (int n = 0; n < 300; n++) begin
      logic [1:0] rs;
      logic       rd;
      logic [3:0] rv;
      rs = 2'($urandom_range(3));
      rd = 1'($urandom_range(1));
      rv = 4'($urandom_range(15));
      run_op(rs, rd, rv, req_of(rs, rd), got);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule